// File: doc/BRIEF.md
# Privileged Opcode Trap Checker

This block sits beside the decode stage of a core that runs a 16-bit fixed-length instruction set. The core has two modes, supervisor and user. The block is told the opcode in decode, whether that opcode is valid, the mode bit of the status register and whether the instruction sits in a branch delay slot. From these it sorts the opcode into a privileged or an unprivileged group.

When a privileged opcode is valid in user mode, the block raises an illegal-instruction trap request. It also withholds permission for any status-register write that the opcode would perform. A return-from-exception that passes the mode check but sits in a delay slot raises the slot-illegal trap instead. The block also produces the value that a status-register load may write: the load data with every non-writable bit forced to zero. An opcode outside every listed group produces neither a trap nor a flag, and the rest of the decoder handles it as usual.

Top module: `priv_opcode_checker`

## Requirements
- R1: When `op_valid` is 1, `sr_supervisor` is 0 and the opcode is privileged (R2 to R5), `trap_illegal` is 1 in the next cycle.
- R2: Exactly the opcodes 0x0038, 0x002B and 0x001B are privileged, compared on all 16 bits (so 0x0138 and 0x0039 are not).
- R3: Opcodes whose value ANDed with 0xF08F equals 0x408E, 0x4087, 0x0082 or 0x4083 (banked-register transfers) are privileged.
- R4: Opcodes whose value ANDed with 0xF0FF equals 0x400E or 0x4007 (status loads) or 0x0002 or 0x4003 (status stores) are privileged.
- R5: Opcodes whose value ANDed with 0xF0FF equals any of 0x402E, 0x4027, 0x0022, 0x4023, 0x403E, 0x4037, 0x0032, 0x4033, 0x404E, 0x4047, 0x0042, 0x4043, 0x40FA, 0x40F6, 0x00FA or 0x40F2 are privileged.
- R6: Opcodes whose value ANDed with 0xF0FF equals any of 0x401E, 0x4017, 0x0012, 0x4013, 0x400A, 0x4006, 0x000A, 0x4002, 0x401A, 0x4016, 0x001A, 0x4012, 0x402A, 0x4026, 0x002A, 0x4022, 0x405A, 0x4056, 0x005A or 0x4052 never trap, and for them `priv_class` is 0.
- R7: `sr_wr_value` is `sr_load_data` ANDed with 0x700083F3, registered every cycle. `sr_wr_en` is 1 in the next cycle only for a valid status load (R4) in supervisor mode. It stays 0 for a status load in user mode.
- R8: Opcode 0x002B in user mode raises `trap_illegal` and not `trap_slot_illegal`, whether or not it is in a delay slot. In supervisor mode with `in_delay_slot` at 1 it raises `trap_slot_illegal` only.
- R9: In supervisor mode, no valid opcode raises `trap_illegal`, and `priv_class` is still 1 in the next cycle for every privileged opcode.
- R10: When `op_valid` is 0, all trap, class and enable outputs are 0 in the next cycle. `trap_illegal` and `trap_slot_illegal` are never 1 together. After reset all outputs are 0.
- R11: Opcodes that no listed group matches produce no trap and a `priv_class` of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Opcode in decode is valid this cycle |
| opcode | input | 16 | Opcode in decode |
| sr_supervisor | input | 1 | Mode bit of the status register; 1 is supervisor mode |
| in_delay_slot | input | 1 | Opcode sits in a branch delay slot |
| sr_load_data | input | 32 | Value that a status load would write |
| trap_illegal | output | 1 | Illegal-instruction trap request, one cycle |
| trap_slot_illegal | output | 1 | Slot-illegal trap request, one cycle |
| priv_class | output | 1 | Opcode was in a privileged group |
| sr_wr_en | output | 1 | Status load is permitted to write |
| sr_wr_value | output | 32 | Load data with the non-writable bits cleared |

## Verification
Every result of this block comes from a single register stage. The trap requests, the class flag, the write enable and the masked value all appear one clock edge after the opcode and its qualifiers are applied. The driver applies each stimulus on a falling edge and pushes the expected result into a queue. The monitor pops that result and compares it 1 ns after the next rising edge, which is the edge that captures the stimulus, so each comparison lines up with exactly one stimulus.

// File: rtl/priv_chk_pkg.sv
package priv_chk_pkg;

    localparam int OP_W   = 16;
    localparam int SR_W   = 32;

    localparam logic [OP_W-1:0] CTL_MASK  = 16'hF0FF;
    localparam logic [OP_W-1:0] BANK_MASK = 16'hF08F;
    localparam logic [SR_W-1:0] SR_WR_MASK = 32'h700083F3;

    localparam logic [OP_W-1:0] OP_TLB_LOAD = 16'h0038;
    localparam logic [OP_W-1:0] OP_RET_EXC  = 16'h002B;
    localparam logic [OP_W-1:0] OP_SLEEP    = 16'h001B;

    typedef enum logic [2:0] {
        GRP_OTHER,
        GRP_EXACT,
        GRP_BANKED,
        GRP_SR_LOAD,
        GRP_SR_STORE,
        GRP_CTRL_PRIV,
        GRP_CTRL_FREE
    } op_group_e;

    typedef struct packed {
        op_group_e grp;
        logic      privileged;
        logic      is_ret_exc;
        logic      sr_load;
    } op_class_t;

    typedef struct packed {
        logic ill;
        logic slot;
        logic priv;
        logic sr_we;
    } trap_req_t;

    function automatic logic is_banked(logic [OP_W-1:0] op);
        logic [OP_W-1:0] m;
        m = op & BANK_MASK;
        case (m)
            16'h408E, 16'h4087, 16'h0082, 16'h4083: return 1'b1;
            default:                                return 1'b0;
        endcase
    endfunction

    function automatic op_group_e ctl_group(logic [OP_W-1:0] op);
        logic [OP_W-1:0] m;
        m = op & CTL_MASK;
        case (m)
            16'h400E, 16'h4007: return GRP_SR_LOAD;
            16'h0002, 16'h4003: return GRP_SR_STORE;
            16'h402E, 16'h4027, 16'h0022, 16'h4023,
            16'h403E, 16'h4037, 16'h0032, 16'h4033,
            16'h404E, 16'h4047, 16'h0042, 16'h4043,
            16'h40FA, 16'h40F6, 16'h00FA, 16'h40F2: return GRP_CTRL_PRIV;
            16'h401E, 16'h4017, 16'h0012, 16'h4013,
            16'h400A, 16'h4006, 16'h000A, 16'h4002,
            16'h401A, 16'h4016, 16'h001A, 16'h4012,
            16'h402A, 16'h4026, 16'h002A, 16'h4022,
            16'h405A, 16'h4056, 16'h005A, 16'h4052: return GRP_CTRL_FREE;
            default:                                return GRP_OTHER;
        endcase
    endfunction

    function automatic logic group_is_priv(op_group_e g);
        case (g)
            GRP_EXACT, GRP_BANKED, GRP_SR_LOAD,
            GRP_SR_STORE, GRP_CTRL_PRIV: return 1'b1;
            default:                     return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/priv_opclass_decode.sv
module priv_opclass_decode
    import priv_chk_pkg::*;
(
    input  logic [OP_W-1:0] opcode,
    output op_class_t       cls
);

    logic      exact_hit;
    logic      bank_hit;
    op_group_e ctl_grp;
    op_group_e grp;

    always_comb begin
        exact_hit = (opcode == OP_TLB_LOAD) || (opcode == OP_RET_EXC) ||
                    (opcode == OP_SLEEP);
        bank_hit  = is_banked(opcode);
        ctl_grp   = ctl_group(opcode);
        if (exact_hit) begin
            grp = GRP_EXACT;
        end else if (bank_hit) begin
            grp = GRP_BANKED;
        end else begin
            grp = ctl_grp;
        end
        cls.grp        = grp;
        cls.privileged = group_is_priv(grp);
        cls.is_ret_exc = (opcode == OP_RET_EXC);
        cls.sr_load    = (grp == GRP_SR_LOAD);
    end

endmodule

// File: rtl/priv_trap_arbiter.sv
module priv_trap_arbiter
    import priv_chk_pkg::*;
(
    input  logic      op_valid,
    input  op_class_t cls,
    input  logic      sr_supervisor,
    input  logic      in_delay_slot,
    output trap_req_t req
);

    logic priv_hit;
    logic mode_fail;

    always_comb begin
        priv_hit  = op_valid && cls.privileged;
        mode_fail = priv_hit && !sr_supervisor;
        req.priv  = priv_hit;
        req.ill   = mode_fail;
        // Privilege is checked before the delay-slot rule for return-from-exception.
        req.slot  = !mode_fail && op_valid && cls.is_ret_exc && in_delay_slot;
        req.sr_we = op_valid && cls.sr_load && !mode_fail;
    end

endmodule

// File: rtl/priv_sr_write_mask.sv
module priv_sr_write_mask
    import priv_chk_pkg::*;
#(
    parameter int W = SR_W
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        if (SR_WR_MASK[gi]) begin : g_keep
            assign dout[gi] = din[gi];
        end else begin : g_zero
            assign dout[gi] = 1'b0;
        end
    end

endmodule

// File: rtl/priv_opcode_checker.sv
module priv_opcode_checker
    import priv_chk_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            op_valid,
    input  logic [OP_W-1:0] opcode,
    input  logic            sr_supervisor,
    input  logic            in_delay_slot,
    input  logic [SR_W-1:0] sr_load_data,
    output logic            trap_illegal,
    output logic            trap_slot_illegal,
    output logic            priv_class,
    output logic            sr_wr_en,
    output logic [SR_W-1:0] sr_wr_value
);

    op_class_t       cls;
    trap_req_t       req;
    logic [SR_W-1:0] masked;

    priv_opclass_decode u_decode (
        .opcode (opcode),
        .cls    (cls)
    );

    priv_trap_arbiter u_arb (
        .op_valid      (op_valid),
        .cls           (cls),
        .sr_supervisor (sr_supervisor),
        .in_delay_slot (in_delay_slot),
        .req           (req)
    );

    priv_sr_write_mask #(.W(SR_W)) u_mask (
        .din  (sr_load_data),
        .dout (masked)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            trap_illegal      <= 1'b0;
            trap_slot_illegal <= 1'b0;
            priv_class        <= 1'b0;
            sr_wr_en          <= 1'b0;
            sr_wr_value       <= '0;
        end else begin
            trap_illegal      <= req.ill;
            trap_slot_illegal <= req.slot;
            priv_class        <= req.priv;
            sr_wr_en          <= req.sr_we;
            sr_wr_value       <= masked;
        end
    end

    AST_TRAP_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({trap_illegal, trap_slot_illegal})); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> !trap_illegal && !trap_slot_illegal && !priv_class && !sr_wr_en); // R10

    AST_USER_PRIV_TRAP: assert property (@(posedge clk) disable iff (rst)
        op_valid && !sr_supervisor |=> (priv_class == trap_illegal)); // R1

    AST_SUP_NO_ILL: assert property (@(posedge clk) disable iff (rst)
        sr_supervisor |=> !trap_illegal); // R9

    AST_SLOT_NEEDS_SUP: assert property (@(posedge clk) disable iff (rst)
        trap_slot_illegal |-> $past(sr_supervisor && in_delay_slot && op_valid)); // R8

    AST_WR_VALUE_MASKED: assert property (@(posedge clk) disable iff (rst)
        (sr_wr_value & ~SR_WR_MASK) == '0); // R7

    AST_WE_NOT_USER: assert property (@(posedge clk) disable iff (rst)
        sr_wr_en |-> $past(sr_supervisor) && !trap_illegal); // R7

endmodule

// File: tb/priv_opcode_checker_tb.sv
module priv_opcode_checker_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [15:0] opcode = 16'h0;
    logic        sr_supervisor = 1'b0;
    logic        in_delay_slot = 1'b0;
    logic [31:0] sr_load_data = 32'h0;
    logic        trap_illegal;
    logic        trap_slot_illegal;
    logic        priv_class;
    logic        sr_wr_en;
    logic [31:0] sr_wr_value;

    int checks = 0;
    int fails  = 0;
    logic [35:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    priv_opcode_checker u_dut (
        .clk               (clk),
        .rst               (rst),
        .op_valid          (op_valid),
        .opcode            (opcode),
        .sr_supervisor     (sr_supervisor),
        .in_delay_slot     (in_delay_slot),
        .sr_load_data      (sr_load_data),
        .trap_illegal      (trap_illegal),
        .trap_slot_illegal (trap_slot_illegal),
        .priv_class        (priv_class),
        .sr_wr_en          (sr_wr_en),
        .sr_wr_value       (sr_wr_value)
    );

    function automatic logic m_sr_load(logic [15:0] op);
        casez (op)
            16'b0100_????_0000_1110, 16'b0100_????_0000_0111: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic m_priv(logic [15:0] op);
        if (op == 16'h0038 || op == 16'h002B || op == 16'h001B) return 1'b1;
        casez (op)
            16'b0100_????_1???_1110, 16'b0100_????_1???_0111,
            16'b0000_????_1???_0010, 16'b0100_????_1???_0011: return 1'b1;
            16'b0000_????_0000_0010, 16'b0100_????_0000_0011: return 1'b1;
            16'b0100_????_0010_1110, 16'b0100_????_0010_0111,
            16'b0000_????_0010_0010, 16'b0100_????_0010_0011,
            16'b0100_????_0011_1110, 16'b0100_????_0011_0111,
            16'b0000_????_0011_0010, 16'b0100_????_0011_0011,
            16'b0100_????_0100_1110, 16'b0100_????_0100_0111,
            16'b0000_????_0100_0010, 16'b0100_????_0100_0011,
            16'b0100_????_1111_1010, 16'b0100_????_1111_0110,
            16'b0000_????_1111_1010, 16'b0100_????_1111_0010: return 1'b1;
            default: return m_sr_load(op);
        endcase
    endfunction

    task automatic drive(input logic [15:0] op, input logic sup, input logic ds,
                         input logic [31:0] data, input logic vld, input string tag);
        logic p, ill, slot, we;
        @(negedge clk);
        op_valid      = vld;
        opcode        = op;
        sr_supervisor = sup;
        in_delay_slot = ds;
        sr_load_data  = data;
        p    = vld && m_priv(op);
        ill  = p && !sup;
        slot = vld && sup && ds && (op == 16'h002B);
        we   = vld && sup && m_sr_load(op);
        exp_q.push_back({ill, slot, p, we, data & 32'h700083F3});
        tag_q.push_back(tag);
    endtask

    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [35:0] e;
            logic [35:0] a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {trap_illegal, trap_slot_illegal, priv_class, sr_wr_en, sr_wr_value};
            checks++;
            if (a !== e) begin
                fails++;
                $display("FAIL %s op=%h: actual %h expected %h", t, opcode, a, e);
            end
        end
    end

    initial begin
        #800000;
        fails++;
        $display("FAIL R10 watchdog expired: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if ({trap_illegal, trap_slot_illegal, priv_class, sr_wr_en, sr_wr_value} !== 36'h0) begin
            fails++;
            $display("FAIL R10 reset state: actual %b%b%b%b %h expected 0000 0",
                     trap_illegal, trap_slot_illegal, priv_class, sr_wr_en, sr_wr_value);
        end
        // R2 exact encodings, R1 user-mode trap
        drive(16'h0038, 0, 0, 32'h0, 1, "R2 tlb load user");
        drive(16'h001B, 0, 0, 32'h0, 1, "R2 sleep user");
        drive(16'h0138, 0, 0, 32'h0, 1, "R2 near miss 0x0138");
        drive(16'h0039, 0, 0, 32'h0, 1, "R2 near miss 0x0039");
        drive(16'h0038, 1, 0, 32'h0, 1, "R9 tlb load supervisor");
        // R8 return-from-exception priority
        drive(16'h002B, 0, 1, 32'h0, 1, "R8 rte user in slot");
        drive(16'h002B, 1, 1, 32'h0, 1, "R8 rte supervisor in slot");
        drive(16'h002B, 1, 0, 32'h0, 1, "R8 rte supervisor no slot");
        drive(16'h002B, 0, 0, 32'h0, 1, "R1 rte user");
        // R3 banked transfers
        drive(16'h41FE, 0, 0, 32'h0, 1, "R3 banked load reg");
        drive(16'h4C87, 0, 0, 32'h0, 1, "R3 banked load postinc");
        drive(16'h0F82, 0, 0, 32'h0, 1, "R3 banked store");
        drive(16'h4A93, 1, 0, 32'h0, 1, "R3 banked store predec supervisor");
        // R4 and R7 status transfers
        drive(16'h430E, 0, 0, 32'hFFFFFFFF, 1, "R4 R7 status load user");
        drive(16'h430E, 1, 0, 32'hFFFFFFFF, 1, "R7 status load supervisor");
        drive(16'h4507, 1, 0, 32'h12345678, 1, "R7 status load postinc supervisor");
        drive(16'h0602, 0, 0, 32'h0, 1, "R4 status store user");
        drive(16'h4B03, 0, 0, 32'h0, 1, "R4 status store predec user");
        // R5 privileged control registers
        drive(16'h452E, 0, 0, 32'h0, 1, "R5 vector base load");
        drive(16'h4237, 0, 0, 32'h0, 1, "R5 saved status load");
        drive(16'h0742, 0, 0, 32'h0, 1, "R5 saved pc store");
        drive(16'h48F2, 0, 0, 32'h0, 1, "R5 debug base store");
        drive(16'h00FA, 1, 0, 32'h0, 1, "R5 debug base store supervisor");
        // R6 free control registers
        drive(16'h451E, 0, 0, 32'h0, 1, "R6 global base");
        drive(16'h4306, 0, 0, 32'h0, 1, "R6 mac high");
        drive(16'h0A1A, 0, 0, 32'h0, 1, "R6 mac low");
        drive(16'h4C22, 0, 0, 32'h0, 1, "R6 procedure reg");
        drive(16'h415A, 0, 1, 32'h0, 1, "R6 fpu comm");
        drive(16'h4312, 0, 0, 32'h0, 1, "R6 mac low predec");
        // R11 unlisted
        drive(16'h0009, 0, 0, 32'h0, 1, "R11 nop");
        drive(16'hE123, 0, 0, 32'h0, 1, "R11 immediate move");
        drive(16'h4084, 0, 0, 32'h0, 1, "R11 near banked");
        drive(16'h402B, 0, 1, 32'h0, 1, "R11 jump form");
        // R10 invalid strobe
        drive(16'h0038, 0, 0, 32'h0, 0, "R10 invalid privileged user");
        drive(16'h002B, 1, 1, 32'hFFFFFFFF, 0, "R10 invalid rte slot");
        drive(16'h400E, 1, 0, 32'hFFFFFFFF, 0, "R10 invalid status load");
        // R1 mixed pseudo-random sweep
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            drive({lfsr[15:12] & 4'h4, lfsr[11:0]}, lfsr[3], lfsr[6],
                  {lfsr, ~lfsr}, lfsr[9] | lfsr[1], "R1 R9 sweep");
        end
        drive(16'h0000, 0, 0, 32'h0, 0, "R10 idle tail");
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule